// File: doc/BRIEF.md
# Event-Detecting GPIO Bank with Two Interrupt Banks and Wakeup

This block manages 32 general-purpose pins behind a 32-bit register file that may be accessed a byte, a halfword or a word at a time. Each pin can be set up as an input or as a driven output. Every input pin can watch for four conditions at once: a rising edge, a falling edge, a high level and a low level, each with its own enable bit.

A detected condition marks the pin in two separate status registers at once. Each status register has its own enable mask and its own interrupt output, so two processors can each service the pins they own. Status bits are cleared by writing ones, but a level condition that still holds marks its bit again straight away. A wake enable mask drives a wake output, which is gated by the power-mode fields of the configuration register. Set-only and clear-only write aliases let software change single bits of the interrupt enables, the wake enables and the output data without a read-modify-write.

Top module: `gpio_evt_bank`

## Requirements
- R1: After reset, the direction register (0x34) reads all ones, which makes every pin an input. Both status registers (0x18, 0x28), both enables (0x1C, 0x2C), the wake enable (0x20), the four detect registers and data out (0x3C) read zero. The version word at 0x00 reads the REV_ID parameter (default 0x31), and 0x14 reads 1.
- R2: A pin whose direction bit is 1 raises an event on a rising edge if its bit at 0x48 is set, on a falling edge if its bit at 0x4C is set, while high if its bit at 0x44 is set, and while low if its bit at 0x40 is set. A pin whose direction bit is 0 raises no event.
- R3: An event sets the pin's bit in status A (0x18) and in status B (0x28) in the same clock. irq_a is the OR of status A AND enable A (0x1C), and irq_b is the OR of status B AND enable B (0x2C).
- R4: Writing ones to a status register clears those bits. A bit whose level condition still holds is set again in the same clock, and a bit with no active condition stays clear.
- R5: These write aliases exist: 0x64 sets and 0x60 clears enable A; 0x74 sets and 0x70 clears enable B; 0x84 sets and 0x80 clears the wake enable; 0x94 sets and 0x90 clears data out. A read of an alias returns the register it acts on.
- R6: bus_size selects the access width: 0 for a byte, 1 for a halfword, 2 for a word. bus_addr[1:0] gives the byte offset, and bus_wdata is right-aligned. A narrower write to a plain register replaces only the addressed byte lanes. A read returns the addressed lanes right-aligned, with zeros above the access width.
- R7: A narrower write to a status register or to an alias acts only on the addressed byte lanes; every other bit keeps its value.
- R8: The configuration register (0x10) keeps only bits 0, 2, 3 and 4. A write with bit 1 set returns every register to its reset value and then stores the masked written value.
- R9: The control register (0x30) keeps bits 2:0, the debounce time (0x54) keeps bits 7:0, and the debounce enable (0x50) keeps all 32 bits. None of these affects any other behaviour. Writes to 0x00, 0x14 and 0x38 are ignored, and 0x38 reads the sampled pins.
- R10: wake is high for one clock after an event cycle only when three things hold: configuration bit 2 is set, configuration bits 4:3 are nonzero, and the pin's wake enable bit is set.
- R11: pin_out equals data out, and pin_drive is the bitwise inverse of the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte address within the bank |
| bus_size | input | 2 | Access width: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data for bus_addr, right-aligned (combinational) |
| pin_in | input | 32 | Pin levels, sampled each clock |
| pin_out | output | 32 | Output data value |
| pin_drive | output | 32 | 1 where the pin is driven as an output |
| irq_a | output | 1 | Interrupt line for bank A |
| irq_b | output | 1 | Interrupt line for bank B |
| wake | output | 1 | Wake request, one clock per qualifying event cycle |

## Verification
The properties assume one bus operation per cycle, with bus_size never equal to 3 and every narrower access kept inside a single aligned word. They also assume pin_in changes only between clock edges. The stimulus drives pins and the bus on the falling clock edge and holds every pin change for three clocks, so each change is sampled and turned into status before it is read. All halfword accesses use offsets 0 or 2.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  localparam int DW    = 32;
  localparam int NBANK = 2;

  typedef enum logic [4:0] {
    RG_NONE, RG_REV, RG_SYSCFG, RG_SYSSTAT, RG_ST_A, RG_EN_A, RG_WKEN,
    RG_ST_B, RG_EN_B, RG_CTRL, RG_OE, RG_DIN, RG_DOUT, RG_LVL_LO, RG_LVL_HI,
    RG_RISE, RG_FALL, RG_DBE, RG_DBT, RG_ENA_CLR, RG_ENA_SET, RG_ENB_CLR,
    RG_ENB_SET, RG_WK_CLR, RG_WK_SET, RG_DO_CLR, RG_DO_SET
  } reg_id_e;

  function automatic logic [4:0] lane_shift(input logic [1:0] off);
    return {off, 3'b000};
  endfunction

  function automatic logic [DW-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // A full-word write is never shifted; narrower ones move to their lane.
  function automatic logic [4:0] write_shift(input logic [1:0] sz, input logic [1:0] off);
    return (sz >= 2'd2) ? 5'd0 : lane_shift(off);
  endfunction

  function automatic logic [DW-1:0] place_lanes(input logic [DW-1:0] wdata,
                                                input logic [1:0] sz,
                                                input logic [1:0] off);
    return (wdata & size_mask(sz)) << write_shift(sz, off);
  endfunction

  function automatic logic [DW-1:0] read_lanes(input logic [DW-1:0] word,
                                               input logic [1:0] sz,
                                               input logic [1:0] off);
    return (word >> lane_shift(off)) & size_mask(sz);
  endfunction

  function automatic reg_id_e decode_reg(input logic [7:0] a);
    case ({a[7:2], 2'b00})
      8'h00: return RG_REV;
      8'h10: return RG_SYSCFG;
      8'h14: return RG_SYSSTAT;
      8'h18: return RG_ST_A;
      8'h1C: return RG_EN_A;
      8'h20: return RG_WKEN;
      8'h28: return RG_ST_B;
      8'h2C: return RG_EN_B;
      8'h30: return RG_CTRL;
      8'h34: return RG_OE;
      8'h38: return RG_DIN;
      8'h3C: return RG_DOUT;
      8'h40: return RG_LVL_LO;
      8'h44: return RG_LVL_HI;
      8'h48: return RG_RISE;
      8'h4C: return RG_FALL;
      8'h50: return RG_DBE;
      8'h54: return RG_DBT;
      8'h60: return RG_ENA_CLR;
      8'h64: return RG_ENA_SET;
      8'h70: return RG_ENB_CLR;
      8'h74: return RG_ENB_SET;
      8'h80: return RG_WK_CLR;
      8'h84: return RG_WK_SET;
      8'h90: return RG_DO_CLR;
      8'h94: return RG_DO_SET;
      default: return RG_NONE;
    endcase
  endfunction

  // Per-line event: edges against the previous sample, levels against now.
  function automatic logic [DW-1:0] line_events(input logic [DW-1:0] now,
                                                input logic [DW-1:0] prev,
                                                input logic [DW-1:0] dir_in,
                                                input logic [DW-1:0] lo_en,
                                                input logic [DW-1:0] hi_en,
                                                input logic [DW-1:0] rise_en,
                                                input logic [DW-1:0] fall_en);
    logic [DW-1:0] edges, levels;
    edges  = (now & ~prev & rise_en) | (~now & prev & fall_en);
    levels = (now & hi_en) | (~now & lo_en);
    return dir_in & (edges | levels);
  endfunction

endpackage

// File: rtl/gpio_evt_decode.sv
module gpio_evt_decode
  import gpio_evt_pkg::*;
(
  input  logic          bus_en,
  input  logic          bus_wr,
  input  logic [7:0]    bus_addr,
  input  logic [1:0]    bus_size,
  input  logic [DW-1:0] bus_wdata,
  output reg_id_e       reg_id,
  output logic          wr_stb,
  output logic [DW-1:0] wplace,
  output logic [DW-1:0] wmask
);

  assign reg_id = decode_reg(bus_addr);
  assign wr_stb = bus_en && bus_wr && (reg_id != RG_NONE);
  assign wplace = place_lanes(bus_wdata, bus_size, bus_addr[1:0]);
  assign wmask  = size_mask(bus_size) << write_shift(bus_size, bus_addr[1:0]);

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_evt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] pin_in,
  input  logic [DW-1:0] dir_in,
  input  logic [DW-1:0] lo_en,
  input  logic [DW-1:0] hi_en,
  input  logic [DW-1:0] rise_en,
  input  logic [DW-1:0] fall_en,
  output logic [DW-1:0] in_q,
  output logic [DW-1:0] evt
);

  logic [DW-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= '0;
      prev_q <= '0;
    end else begin
      in_q   <= pin_in;
      prev_q <= in_q;
    end
  end

  assign evt = line_events(in_q, prev_q, dir_in, lo_en, hi_en, rise_en, fall_en);

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_evt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic [DW-1:0] evt,
  input  logic [DW-1:0] st_clr,
  input  logic          en_load,
  input  logic [DW-1:0] en_val,
  input  logic [DW-1:0] en_set,
  input  logic [DW-1:0] en_clr,
  output logic [DW-1:0] status,
  output logic [DW-1:0] enable,
  output logic          irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else if (srst) begin
      status <= '0;
      enable <= '0;
    end else begin
      // A new event wins over a clear in the same cycle.
      status <= (status & ~st_clr) | evt;
      if (en_load) enable <= en_val;
      else         enable <= (enable | en_set) & ~en_clr;
    end
  end

  assign irq = |(status & enable);

endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank
  import gpio_evt_pkg::*;
#(
  parameter logic [31:0] REV_ID = 32'h0000_0031,
  parameter int          DBT_W  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_wr,
  input  logic [7:0]    bus_addr,
  input  logic [1:0]    bus_size,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [31:0]   pin_in,
  output logic [31:0]   pin_out,
  output logic [31:0]   pin_drive,
  output logic          irq_a,
  output logic          irq_b,
  output logic          wake
);

  localparam int          CFG_W    = 5;
  localparam logic [4:0]  CFG_KEEP = 5'h1D;
  localparam int          CTRL_W   = 3;

  reg_id_e       reg_id;
  logic          wr_stb;
  logic [DW-1:0] wplace, wmask, wmerge, rd_word;
  logic          srst;

  logic [CFG_W-1:0]  syscfg;
  logic [CTRL_W-1:0] ctrl;
  logic [DBT_W-1:0]  dbt;
  logic [DW-1:0]     wken, oe, dout, lvl_lo, lvl_hi, rise, fall, dbe;
  logic [DW-1:0]     in_q, evt;
  logic              wake_q;

  logic [NBANK-1:0][DW-1:0] st_q, en_q, st_clr, en_set, en_clr;
  logic [NBANK-1:0]         en_load, irq_v;

  gpio_evt_decode u_decode (
    .bus_en   (bus_en),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_size (bus_size),
    .bus_wdata(bus_wdata),
    .reg_id   (reg_id),
    .wr_stb   (wr_stb),
    .wplace   (wplace),
    .wmask    (wmask)
  );

  gpio_evt_detect u_detect (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in (pin_in),
    .dir_in (oe),
    .lo_en  (lvl_lo),
    .hi_en  (lvl_hi),
    .rise_en(rise),
    .fall_en(fall),
    .in_q   (in_q),
    .evt    (evt)
  );

  // Plain registers take the addressed lanes merged into the current word.
  assign wmerge = (rd_word & ~wmask) | wplace;
  assign srst   = wr_stb && (reg_id == RG_SYSCFG) && wmerge[1];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam reg_id_e ID_ST  = (b == 0) ? RG_ST_A    : RG_ST_B;
    localparam reg_id_e ID_EN  = (b == 0) ? RG_EN_A    : RG_EN_B;
    localparam reg_id_e ID_SET = (b == 0) ? RG_ENA_SET : RG_ENB_SET;
    localparam reg_id_e ID_CLR = (b == 0) ? RG_ENA_CLR : RG_ENB_CLR;

    assign st_clr[b]  = (wr_stb && reg_id == ID_ST)  ? wplace : '0;
    assign en_load[b] = wr_stb && (reg_id == ID_EN);
    assign en_set[b]  = (wr_stb && reg_id == ID_SET) ? wplace : '0;
    assign en_clr[b]  = (wr_stb && reg_id == ID_CLR) ? wplace : '0;

    gpio_irq_bank u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .srst   (srst),
      .evt    (evt),
      .st_clr (st_clr[b]),
      .en_load(en_load[b]),
      .en_val (wmerge),
      .en_set (en_set[b]),
      .en_clr (en_clr[b]),
      .status (st_q[b]),
      .enable (en_q[b]),
      .irq    (irq_v[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syscfg <= '0;  wken <= '0;   ctrl <= '0;   oe   <= '1;
      dout   <= '0;  lvl_lo <= '0; lvl_hi <= '0; rise <= '0;
      fall   <= '0;  dbe  <= '0;   dbt  <= '0;
    end else if (srst) begin
      syscfg <= wmerge[CFG_W-1:0] & CFG_KEEP;
      wken <= '0;    ctrl <= '0;   oe   <= '1;
      dout   <= '0;  lvl_lo <= '0; lvl_hi <= '0; rise <= '0;
      fall   <= '0;  dbe  <= '0;   dbt  <= '0;
    end else if (wr_stb) begin
      case (reg_id)
        RG_SYSCFG: syscfg <= wmerge[CFG_W-1:0] & CFG_KEEP;
        RG_WKEN:   wken   <= wmerge;
        RG_WK_SET: wken   <= wken | wplace;
        RG_WK_CLR: wken   <= wken & ~wplace;
        RG_CTRL:   ctrl   <= wmerge[CTRL_W-1:0];
        RG_OE:     oe     <= wmerge;
        RG_DOUT:   dout   <= wmerge;
        RG_DO_SET: dout   <= dout | wplace;
        RG_DO_CLR: dout   <= dout & ~wplace;
        RG_LVL_LO: lvl_lo <= wmerge;
        RG_LVL_HI: lvl_hi <= wmerge;
        RG_RISE:   rise   <= wmerge;
        RG_FALL:   fall   <= wmerge;
        RG_DBE:    dbe    <= wmerge;
        RG_DBT:    dbt    <= wmerge[DBT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wake_q <= 1'b0;
    else if (srst)  wake_q <= 1'b0;
    else            wake_q <= syscfg[2] && (syscfg[4:3] != 2'b00) && |(evt & wken);
  end

  always_comb begin
    case (reg_id)
      RG_REV:                         rd_word = REV_ID;
      RG_SYSCFG:                      rd_word = {{(DW-CFG_W){1'b0}}, syscfg};
      RG_SYSSTAT:                     rd_word = 32'h1;
      RG_ST_A:                        rd_word = st_q[0];
      RG_EN_A, RG_ENA_SET, RG_ENA_CLR: rd_word = en_q[0];
      RG_WKEN, RG_WK_SET, RG_WK_CLR:  rd_word = wken;
      RG_ST_B:                        rd_word = st_q[1];
      RG_EN_B, RG_ENB_SET, RG_ENB_CLR: rd_word = en_q[1];
      RG_CTRL:                        rd_word = {{(DW-CTRL_W){1'b0}}, ctrl};
      RG_OE:                          rd_word = oe;
      RG_DIN:                         rd_word = in_q;
      RG_DOUT, RG_DO_SET, RG_DO_CLR:  rd_word = dout;
      RG_LVL_LO:                      rd_word = lvl_lo;
      RG_LVL_HI:                      rd_word = lvl_hi;
      RG_RISE:                        rd_word = rise;
      RG_FALL:                        rd_word = fall;
      RG_DBE:                         rd_word = dbe;
      RG_DBT:                         rd_word = {{(DW-DBT_W){1'b0}}, dbt};
      default:                        rd_word = '0;
    endcase
  end

  assign bus_rdata = read_lanes(rd_word, bus_size, bus_addr[1:0]);
  assign pin_out   = dout;
  assign pin_drive = ~oe;
  assign irq_a     = irq_v[0];
  assign irq_b     = irq_v[1];
  assign wake      = wake_q;

endmodule

// File: rtl/gpio_evt_bank_chk.sv
module gpio_evt_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        srst,
  input logic [31:0] evt,
  input logic [31:0] st_a,
  input logic [31:0] st_b,
  input logic [31:0] en_a,
  input logic [31:0] clr_a,
  input logic        irq_a,
  input logic        wake,
  input logic [4:0]  cfg
);

  AST_STATUS_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_a & ~$past(st_a) & ~$past(evt)) == 32'h0)); // R2

  AST_BANKS_SET_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    !srst |=> (($past(evt) & ~(st_a & st_b)) == 32'h0)); // R3

  AST_IRQ_A_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_a == 32'h0) |-> !irq_a); // R3

  AST_CLEAR_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !srst |=> (($past(clr_a & ~evt) & st_a) == 32'h0)); // R4

  AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (st_a == 32'h0 && st_b == 32'h0 && en_a == 32'h0)); // R8

  AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(cfg[2] && (cfg[4:3] != 2'b00))); // R10

endmodule

bind gpio_evt_bank gpio_evt_bank_chk u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .srst (srst),
  .evt  (evt),
  .st_a (st_q[0]),
  .st_b (st_q[1]),
  .en_a (en_q[0]),
  .clr_a(st_clr[0]),
  .irq_a(irq_a),
  .wake (wake),
  .cfg  (syscfg)
);

// File: tb/test_gpio_evt_bank.sv
module test_gpio_evt_bank;

  localparam logic [7:0] A_REV = 8'h00, A_CFG = 8'h10, A_STAT = 8'h14,
    A_STA = 8'h18, A_ENA = 8'h1C, A_WKEN = 8'h20, A_STB = 8'h28, A_ENB = 8'h2C,
    A_CTRL = 8'h30, A_OE = 8'h34, A_DIN = 8'h38, A_DOUT = 8'h3C, A_LLO = 8'h40,
    A_LHI = 8'h44, A_RISE = 8'h48, A_FALL = 8'h4C, A_DBE = 8'h50, A_DBT = 8'h54,
    A_ENA_C = 8'h60, A_ENA_S = 8'h64, A_ENB_C = 8'h70, A_ENB_S = 8'h74,
    A_WK_C = 8'h80, A_WK_S = 8'h84, A_DO_C = 8'h90, A_DO_S = 8'h94;
  localparam logic [31:0] REV = 32'h0000_0031;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [1:0] bus_size = 2'd2;
  logic [31:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_drive;
  logic irq_a, irq_b, wake;
  int checks = 0, errors = 0, wake_cnt = 0;
  logic [31:0] q;

  always #5 clk = ~clk;

  gpio_evt_bank i_gpio_evt_bank (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_drive(pin_drive), .irq_a(irq_a), .irq_b(irq_b), .wake(wake)
  );

  always @(negedge clk) if (wake === 1'b1) wake_cnt++;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = s;
    #1 d = bus_rdata;
  endtask

  task automatic rchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, 2'd2, v);
    chk(tag, v, exp);
  endtask

  task automatic set_pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic soft_reset();
    wr(A_CFG, 2'd2, 32'h2);
  endtask

  initial begin : main
    logic [7:0]  rw_addr [11];
    logic [31:0] rw_mask [11];
    logic [31:0] pats [4];
    logic [31:0] oes [2];
    logic [31:0] los [3];
    logic [31:0] his [3];
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rchk("R1 oe", A_OE, 32'hFFFF_FFFF);
    rchk("R1 stA", A_STA, 0);
    rchk("R1 stB", A_STB, 0);
    rchk("R1 enA", A_ENA, 0);
    rchk("R1 wken", A_WKEN, 0);
    rchk("R1 rise", A_RISE, 0);
    rchk("R1 dout", A_DOUT, 0);
    rchk("R1 rev", A_REV, REV);
    rchk("R1 sysstat", A_STAT, 32'h1);
    chk("R1 irq/wake", {29'b0, irq_a, irq_b, wake}, 0);

    // R9 read-only words ignore writes
    wr(A_REV, 2'd2, 0); wr(A_STAT, 2'd2, 0); wr(A_DIN, 2'd2, 32'hFFFF_FFFF);
    rchk("R9 rev ro", A_REV, REV);
    rchk("R9 sysstat ro", A_STAT, 32'h1);
    rchk("R9 din ro", A_DIN, 32'h0);

    // R9 storage widths, distinct value per register (all pins outputs)
    wr(A_OE, 2'd2, 32'h0);
    rw_addr = '{A_ENA, A_WKEN, A_ENB, A_CTRL, A_DOUT, A_LLO, A_LHI, A_RISE, A_FALL, A_DBE, A_DBT};
    rw_mask = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h7, 32'hFFFF_FFFF,
                32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                32'hFFFF_FFFF, 32'hFF};
    for (int k = 0; k < 11; k++) wr(rw_addr[k], 2'd2, 32'h9E37_79B9 * (k + 1));
    for (int k = 0; k < 11; k++) begin
      rd(rw_addr[k], 2'd2, q);
      chk($sformatf("R9 storage @%h", rw_addr[k]), q, (32'h9E37_79B9 * (k + 1)) & rw_mask[k]);
    end

    // R8 configuration mask and soft reset
    wr(A_CFG, 2'd2, 32'hFFFF_FFFD);
    rchk("R8 cfg mask", A_CFG, 32'h1D);
    soft_reset();
    rchk("R8 cfg after srst", A_CFG, 0);
    rchk("R8 oe after srst", A_OE, 32'hFFFF_FFFF);
    rchk("R8 enA after srst", A_ENA, 0);
    rchk("R8 lvl hi after srst", A_LHI, 0);
    rchk("R8 dout after srst", A_DOUT, 0);

    // R2 R3 R4 rising-edge sweep over every line
    wr(A_ENA, 2'd2, 32'hFFFF_FFFF);
    wr(A_RISE, 2'd2, 32'hFFFF_FFFF);
    for (int i = 0; i < 32; i++) begin
      set_pins(32'h1 << i);
      rchk("R2 rise stA", A_STA, 32'h1 << i);
      rchk("R3 rise stB", A_STB, 32'h1 << i);
      chk("R3 irq a/b", {30'b0, irq_a, irq_b}, 32'h2);
      wr(A_STA, 2'd2, 32'hFFFF_FFFF);
      wr(A_STB, 2'd2, 32'hFFFF_FFFF);
      set_pins(32'h0);
      rchk("R4 cleared, no fall", A_STA, 0);
      chk("R3 irq a low", {31'b0, irq_a}, 0);
    end

    // R2 falling-edge sweep
    wr(A_RISE, 2'd2, 0);
    wr(A_FALL, 2'd2, 32'hFFFF_FFFF);
    set_pins(32'hFFFF_FFFF);
    for (int i = 0; i < 32; i++) begin
      set_pins(~(32'h1 << i));
      rchk("R2 fall stA", A_STA, 32'h1 << i);
      wr(A_STA, 2'd2, 32'hFFFF_FFFF);
      set_pins(32'hFFFF_FFFF);
      rchk("R2 fall no rise", A_STA, 0);
    end

    // R2 output lines raise nothing
    wr(A_STB, 2'd2, 32'hFFFF_FFFF);
    wr(A_OE, 2'd2, 32'hFFFF_0000);
    set_pins(32'h0);
    rchk("R2 outputs ignored", A_STB, 32'hFFFF_0000);
    soft_reset();

    // R2 R4 level sweep: patterns x directions x level enables
    pats = '{32'h0, 32'hFFFF_FFFF, 32'hA5A5_3C3C, 32'h0F0F_F0F0};
    oes  = '{32'hFFFF_FFFF, 32'h00FF_00FF};
    los  = '{32'h0, 32'hFFFF_FFFF, 32'hFFFF_0000};
    his  = '{32'hFFFF_FFFF, 32'h0, 32'h0000_FFFF};
    for (int p = 0; p < 4; p++)
      for (int o = 0; o < 2; o++)
        for (int l = 0; l < 3; l++) begin
          logic [31:0] e;
          wr(A_OE, 2'd2, oes[o]);
          wr(A_LLO, 2'd2, los[l]);
          wr(A_LHI, 2'd2, his[l]);
          set_pins(pats[p]);
          wr(A_STA, 2'd2, 32'hFFFF_FFFF);
          wr(A_STB, 2'd2, 32'hFFFF_FFFF);
          e = ((pats[p] & his[l]) | (~pats[p] & los[l])) & oes[o];
          rchk("R4 level re-arm A", A_STA, e);
          rchk("R4 level re-arm B", A_STB, e);
        end
    soft_reset();

    // R6 R11 sub-word merge on data out
    wr(A_DOUT, 2'd2, 32'h1122_3344);
    wr(A_DOUT + 8'd2, 2'd0, 32'hAB);
    rchk("R6 byte merge", A_DOUT, 32'h11AB_3344);
    wr(A_DOUT, 2'd1, 32'hBEEF);
    rchk("R6 half merge", A_DOUT, 32'h11AB_BEEF);
    rd(A_DOUT + 8'd3, 2'd0, q); chk("R6 byte read", q, 32'h11);
    rd(A_DOUT + 8'd2, 2'd1, q); chk("R6 half read", q, 32'h11AB);
    chk("R11 pin_out", pin_out, 32'h11AB_BEEF);
    wr(A_OE, 2'd2, 32'h0F0F_0F0F);
    chk("R11 pin_drive", pin_drive, 32'hF0F0_F0F0);
    wr(A_OE, 2'd2, 32'hFFFF_FFFF);

    // R7 R3 partial clears, banks independent
    wr(A_RISE, 2'd2, 32'hFFFF_FFFF);
    set_pins(32'h0);
    wr(A_STA, 2'd2, 32'hFFFF_FFFF);
    wr(A_STB, 2'd2, 32'hFFFF_FFFF);
    set_pins(32'hFFFF_FFFF);
    wr(A_STA + 8'd1, 2'd0, 32'hFF);
    rchk("R7 byte clear A", A_STA, 32'hFFFF_00FF);
    rchk("R3 bank B untouched", A_STB, 32'hFFFF_FFFF);
    wr(A_STB + 8'd2, 2'd1, 32'h00FF);
    rchk("R7 half clear B", A_STB, 32'hFF00_FFFF);

    // R5 R7 aliases
    wr(A_DO_C, 2'd2, 32'hFFFF_FFFF);
    wr(A_DO_S, 2'd2, 32'hF0);
    wr(A_DO_C, 2'd0, 32'h30);
    rchk("R5 dout alias", A_DOUT, 32'hC0);
    rchk("R5 read set alias", A_DO_S, 32'hC0);
    rchk("R5 read clr alias", A_DO_C, 32'hC0);
    wr(A_ENA_S + 8'd1, 2'd0, 32'h01);
    rchk("R7 byte set enA", A_ENA, 32'h100);
    wr(A_ENA_S, 2'd2, 32'h3);
    wr(A_ENA_C, 2'd2, 32'h1);
    rchk("R5 enA set/clr", A_ENA_C, 32'h102);
    wr(A_ENB_S, 2'd2, 32'h8000_0000);
    rchk("R5 enB set", A_ENB, 32'h8000_0000);
    wr(A_ENB_C + 8'd3, 2'd0, 32'h80);
    rchk("R7 byte clr enB", A_ENB, 32'h0);
    wr(A_WK_S, 2'd2, 32'h55);
    wr(A_WK_C, 2'd2, 32'h05);
    rchk("R5 wken alias", A_WKEN, 32'h50);

    // R10 wake gating sweep over enable bit and idle field
    soft_reset();
    wr(A_RISE, 2'd2, 32'h1);
    wr(A_WKEN, 2'd2, 32'h1);
    set_pins(32'h0);
    for (int k = 0; k < 8; k++) begin
      int c0;
      logic [31:0] cfg;
      cfg = (32'(k & 3) << 3) | (32'((k >> 2) & 1) << 2);
      wr(A_CFG, 2'd2, cfg);
      c0 = wake_cnt;
      set_pins(32'h1);
      set_pins(32'h0);
      chk($sformatf("R10 wake cfg=%h", cfg), 32'(wake_cnt - c0),
          (((k >> 2) & 1) == 1 && (k & 3) != 0) ? 32'd1 : 32'd0);
    end
    wr(A_CFG, 2'd2, 32'h0C);
    wr(A_WK_C, 2'd2, 32'h1);
    begin
      int c1;
      c1 = wake_cnt;
      set_pins(32'h1);
      set_pins(32'h0);
      chk("R10 wake needs line enable", 32'(wake_cnt - c1), 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired got=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule